// File: doc/BRIEF.md
# Acknowledged Transmit Message Mailbox

A processor fills an eight-byte message buffer through a byte-wide register port, then sets a send bit. The block streams the buffer to a link-side transmitter over a valid/ready byte interface, highest byte first. It keeps cycling through the message until the far end returns an acknowledge pulse or the processor cancels the send.

While a send is pending, the buffer is closed to writes, so the message in flight cannot be corrupted. Once the send completes or is cancelled, a ready flag reopens the buffer. That flag can drive a level interrupt. The data bytes survive a send, so setting the send bit again transmits the same message. An enable register holds the ready-interrupt enable and three further enable bits, which are kept as plain storage only.

Top module: `msg_tx_mailbox`

## Requirements
- R1: After reset, the status register at 0x0A reads 0x01 (bit 0 is the ready flag). The send register at 0x0C, the enable register at 0x0B and any unmapped address read 0x00, and `irq` and `tx_valid` are 0.
- R2: Message byte k (k = 0..7) is stored at address 0x14 - k, so byte 7 sits at 0x0D and byte 0 at 0x14. While the ready flag is 1, a write there is read back unchanged.
- R3: Writing a value with bit 0 set to 0x0C while ready is 1 starts a send. On the next cycle the ready flag is 0, 0x0C reads 0x01 and `tx_valid` is 1 with byte 7 on `tx_data`.
- R4: While the ready flag is 0, writes to 0x0D..0x14 are ignored and the stored bytes are unchanged.
- R5: A `far_ack` pulse during a send ends it on the next cycle. `tx_valid` drops, 0x0C reads 0x00 and the ready flag is 1.
- R6: Writing a value with bit 0 clear to 0x0C during a send aborts it on the next cycle. `tx_valid` drops, the ready flag is 1 and data writes are accepted again.
- R7: A `far_ack` pulse while no send is active has no effect. The ready flag stays 1 and `tx_valid` stays 0.
- R8: The enable register at 0x0B stores bits 3..0, and bits 7..4 read 0. `irq` is 1 exactly when the ready flag is 1 and enable bit 0 is 1. The status register ignores writes.
- R9: A byte moves when `tx_valid` and `tx_ready` are both 1. The order is byte 7 down to byte 0, then it wraps back to byte 7. While `tx_ready` is 0, `tx_data` holds its value.
- R10: Setting the send bit after an acknowledge retransmits the same stored bytes, starting again from byte 7.
- R11: Writing bit 0 set to 0x0C while a send is active neither restarts nor disturbs the stream position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from `reg_addr`) |
| tx_valid | output | 1 | Link byte valid |
| tx_data | output | 8 | Link byte |
| tx_ready | input | 1 | Link side accepts the byte |
| far_ack | input | 1 | Far-end acknowledge pulse |
| irq | output | 1 | Level interrupt: ready and enabled |

## Verification
The bench builds the block with its default parameters: eight message bytes and a data window starting at 0x0D. With these values the three-bit stream pointer wraps from byte 0 to byte 7 inside a run the bench can watch. The resulting address order can be checked against the byte order seen on the link. The defaults also let the bench collide a data write, a repeated send and a stalled link in one locked interval, and then cancel and resend the same message.

// File: rtl/msg_tx_mailbox.sv
module msg_tx_mailbox #(
  parameter int ADDR_W       = 8,
  parameter int MSG_BYTES    = 8,
  parameter int STAT_ADDR    = 'h0A,
  parameter int IEN_ADDR     = 'h0B,
  parameter int SEND_ADDR    = 'h0C,
  parameter int DATA_HI_ADDR = 'h0D,
  parameter int IEN_BITS     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic              tx_ready,
  input  logic              far_ack,
  output logic              irq
);
  localparam int PW = (MSG_BYTES > 1) ? $clog2(MSG_BYTES) : 1;
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(IEN_ADDR);
  localparam logic [ADDR_W-1:0] A_SEND = ADDR_W'(SEND_ADDR);
  localparam logic [ADDR_W-1:0] A_DHI  = ADDR_W'(DATA_HI_ADDR);
  localparam logic [PW-1:0]     LAST   = PW'(MSG_BYTES - 1);

  logic [7:0]          msg [MSG_BYTES];
  logic                busy;
  logic [PW-1:0]       ptr;
  logic [IEN_BITS-1:0] ien;

  logic [ADDR_W-1:0] off;
  logic              in_data;
  logic [PW-1:0]     idx;

  assign off     = reg_addr - A_DHI;
  assign in_data = (reg_addr >= A_DHI) && (off < ADDR_W'(MSG_BYTES));
  assign idx     = LAST - off[PW-1:0];

  wire send_wr = reg_wr && (reg_addr == A_SEND);
  wire start   = send_wr && reg_wdata[0] && !busy;
  wire abort   = send_wr && !reg_wdata[0] && busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      ptr  <= LAST;
      ien  <= '0;
      for (int k = 0; k < MSG_BYTES; k++) msg[k] <= 8'h00;
    end else begin
      if (busy && (far_ack || abort)) busy <= 1'b0;
      else if (start) busy <= 1'b1;

      if (start) ptr <= LAST;
      else if (busy && tx_ready) ptr <= (ptr == '0) ? LAST : ptr - 1'b1;

      if (reg_wr && reg_addr == A_IEN) ien <= reg_wdata[IEN_BITS-1:0];
      if (reg_wr && in_data && !busy) msg[idx] <= reg_wdata;
    end
  end

  assign tx_valid = busy;
  assign tx_data  = msg[ptr];
  assign irq      = !busy && ien[0];

  always_comb begin
    reg_rdata = 8'h00;
    if (reg_addr == A_STAT)      reg_rdata[0] = !busy;
    else if (reg_addr == A_SEND) reg_rdata[0] = busy;
    else if (reg_addr == A_IEN)  reg_rdata[IEN_BITS-1:0] = ien;
    else if (in_data)            reg_rdata = msg[idx];
  end
endmodule

module mailbox_chk #(
  parameter int ADDR_W    = 8,
  parameter int SEND_ADDR = 'h0C
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [7:0]        reg_wdata,
  input logic              tx_valid,
  input logic [7:0]        tx_data,
  input logic              tx_ready,
  input logic              far_ack,
  input logic              irq
);
  wire send_wr = reg_wr && (reg_addr == ADDR_W'(SEND_ADDR));

  p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_valid && send_wr && reg_wdata[0] && !far_ack |=> tx_valid);

  p_ack_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && far_ack |=> !tx_valid);

  p_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && send_wr && !reg_wdata[0] |=> !tx_valid);

  p_idle_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_valid && far_ack && !send_wr |=> !tx_valid);

  p_irq_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !tx_valid);

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready && !far_ack && !send_wr |=> tx_valid && $stable(tx_data));
endmodule

bind msg_tx_mailbox mailbox_chk #(.ADDR_W(ADDR_W), .SEND_ADDR(SEND_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .tx_valid(tx_valid), .tx_data(tx_data),
  .tx_ready(tx_ready), .far_ack(far_ack), .irq(irq)
);

// File: tb/sim_msg_tx_mailbox.sv
`timescale 1ns/1ps
module sim_msg_tx_mailbox;
  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0, tx_ready = 1'b0, far_ack = 1'b0;
  logic [7:0] reg_addr = 8'h00, reg_wdata = 8'h00;
  logic [7:0] reg_rdata, tx_data;
  logic tx_valid, irq;
  int total = 0, bad = 0;
  logic [7:0] rv;

  always #2.5 clk = ~clk;

  msg_tx_mailbox u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready), .far_ack(far_ack), .irq(irq)
  );

  // {addr, wdata, expected readback}
  localparam logic [23:0] VEC [11] = '{
    24'h0D_87_87, 24'h0E_76_76, 24'h0F_65_65, 24'h10_54_54,
    24'h11_43_43, 24'h12_32_32, 24'h13_21_21, 24'h14_10_10,
    24'h0B_FF_0F, 24'h0A_00_01, 24'h20_5C_00
  };

  function automatic logic [7:0] mb(int k);
    return 8'(8'h11 * k + 8'h10);
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    reg_addr = a; #0.5; d = reg_rdata;
  endtask

  task automatic ack_pulse();
    @(negedge clk); far_ack = 1'b1;
    @(negedge clk); far_ack = 1'b0;
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(8'h0A, rv); check("R1 status", rv, 8'h01);
    rd(8'h0C, rv); check("R1 send", rv, 8'h00);
    rd(8'h0B, rv); check("R1 ien", rv, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);
    check("R1 valid", {7'd0, tx_valid}, 8'h00);

    // R2 / R8 table walk
    for (int i = 0; i < 11; i++) begin
      wr(VEC[i][23:16], VEC[i][15:8]);
      rd(VEC[i][23:16], rv);
      check("R2/R8 table", rv, VEC[i][7:0]);
    end
    check("R8 irq on", {7'd0, irq}, 8'h01);

    // R7 ack while idle
    ack_pulse();
    rd(8'h0A, rv); check("R7 ready kept", rv, 8'h01);
    check("R7 valid", {7'd0, tx_valid}, 8'h00);

    // R3 start
    wr(8'h0C, 8'h01);
    rd(8'h0A, rv); check("R3 ready clr", rv, 8'h00);
    rd(8'h0C, rv); check("R3 send set", rv, 8'h01);
    check("R3 valid", {7'd0, tx_valid}, 8'h01);
    check("R3 first byte", tx_data, mb(7));
    check("R8 irq off", {7'd0, irq}, 8'h00);

    // R4 locked writes, R9 stall
    wr(8'h0D, 8'hFF);
    wr(8'h14, 8'hEE);
    rd(8'h0D, rv); check("R4 locked hi", rv, mb(7));
    rd(8'h14, rv); check("R4 locked lo", rv, mb(0));
    check("R9 stall hold", tx_data, mb(7));

    // R9 streaming order with wrap
    tx_ready = 1'b1;
    for (int i = 0; i < 12; i++) begin
      check("R9 order", tx_data, mb((7 - i) & 7));
      @(negedge clk);
    end
    tx_ready = 1'b0;
    check("R9 pos", tx_data, mb(3));

    // R11 send while active
    wr(8'h0C, 8'h01);
    check("R11 no restart", tx_data, mb(3));
    check("R11 valid", {7'd0, tx_valid}, 8'h01);

    // R5 acknowledge
    ack_pulse();
    check("R5 valid drop", {7'd0, tx_valid}, 8'h00);
    rd(8'h0A, rv); check("R5 ready", rv, 8'h01);
    rd(8'h0C, rv); check("R5 send clr", rv, 8'h00);
    check("R5 irq", {7'd0, irq}, 8'h01);

    // R10 resend same message
    tx_ready = 1'b1;
    wr(8'h0C, 8'h01);
    for (int i = 0; i < 8; i++) begin
      check("R10 resend", tx_data, mb(7 - i));
      @(negedge clk);
    end
    tx_ready = 1'b0;

    // R6 abort
    wr(8'h0C, 8'h00);
    check("R6 valid drop", {7'd0, tx_valid}, 8'h00);
    rd(8'h0A, rv); check("R6 ready", rv, 8'h01);
    wr(8'h14, 8'h5A);
    rd(8'h14, rv); check("R6 write open", rv, 8'h5A);

    // R8 enable cleared
    wr(8'h0B, 8'h0E);
    check("R8 irq masked", {7'd0, irq}, 8'h00);
    rd(8'h0B, rv); check("R8 ien", rv, 8'h0E);

    summary();
  end
endmodule